// File: doc/BRIEF.md
# 1-Wire Rising-Edge Pullup Sequencer

This block decides when the strong pullup transistor on a 1-Wire line conducts, and when the active-low external power-control pin is asserted. It has two modes. In the first, an edge-assist pulse is applied after a released line has crossed a threshold. In the second, a hold-on mode supplies power to slaves after a write slot. The analog slew control and the threshold comparator are outside the block. The block sees only the comparator's flag and a few timing strobes from the slot engine.

Active pullup works as follows. When the low drive is released and the mode is enabled, the sequencer waits for the comparator flag. It then turns the transistor on for a fixed number of clock cycles, and the resistive pullup carries the line after that. The window has one length for standard speed and a shorter one for overdrive. Edges that end a presence pulse or recover from a short get no assist. If the threshold never arrives, a timeout returns the sequencer to idle.

Strong pullup uses the same transistor. It starts at the end of the write slot in which it was armed and lasts until the next command strobe. When it ends, a one-cycle done pulse tells the configuration logic to clear the arming bit.

Top module: `ow_pullup_seq`

## Requirements
- R1: After reset, `pullupOn` is 0, `pwrCtlN` is 1 and `spuDone` is 0.
- R2: With `apuEn` at 0, a release never turns `pullupOn` on, even if `aboveThresh` is high for many cycles.
- R3: With `apuEn` at 1, a release (`releaseEvt` sampled high with `skipEdge` low) leaves `pullupOn` at 0 while `aboveThresh` stays low. Once `aboveThresh` is sampled high, `pullupOn` is 1 from the next cycle.
- R4: With `speedOd` at 0, `pullupOn` stays high for exactly `WIN_STD` consecutive cycles of active pullup and then drops. `pwrCtlN` stays 1 throughout.
- R5: With `speedOd` at 1, the active-pullup window lasts exactly `WIN_OD` cycles.
- R6: A release sampled together with `skipEdge` at 1 (presence-pulse or short-recovery edge) starts no active pullup. A later `aboveThresh` has no effect.
- R7: If `aboveThresh` does not rise within `TMO_CYC` cycles of a release, the sequencer returns to idle. A later `aboveThresh` then turns nothing on.
- R8: A `slotEnd` sampled with `spuEn` at 1 sets `pullupOn` to 1 and `pwrCtlN` to 0 from the next cycle. Both hold, past any active-pullup window length, until `cmdStrobe` is sampled.
- R9: One cycle after `cmdStrobe` is sampled during strong pullup, `pullupOn` is 0, `pwrCtlN` is 1 and `spuDone` is 1. `spuDone` is high for exactly one cycle.
- R10: A strong-pullup start arriving while an active-pullup window is running takes over the transistor. That strong pullup runs beyond the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| apuEn | input | 1 | Active-pullup mode enable |
| spuEn | input | 1 | Strong-pullup armed bit |
| speedOd | input | 1 | 1 selects the overdrive window length |
| releaseEvt | input | 1 | One-cycle strobe: the low drive on the line was released |
| skipEdge | input | 1 | Current rising edge follows a presence pulse or a short |
| aboveThresh | input | 1 | Comparator flag: the line is above the assist threshold |
| slotEnd | input | 1 | Strobe marking the end of the current time slot |
| cmdStrobe | input | 1 | Strobe marking the arrival of the next command |
| pullupOn | output | 1 | Pullup transistor enable |
| pwrCtlN | output | 1 | Active-low external power-control pin |
| spuDone | output | 1 | One-cycle pulse when strong pullup ends |

## Verification
Releases are driven with the assist mode off, with the skip flag set, and with a threshold that arrives after a few cycles or never arrives. Together these separate gating by mode, gating by edge type, waiting on the comparator, and the timeout. The window is measured at both speeds to show that the speed select changes its length. Strong pullup is started from idle and from inside a running assist window. Its end is checked for release of both outputs and for a single-cycle done pulse.

// File: rtl/ow_pullup_pkg.sv
package ow_pullup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_APU  = 2'd2,
    ST_SPU  = 2'd3
  } seqState_t;

  // strobes from control to the cycle counter
  typedef struct packed {
    logic clr;
    logic inc;
  } cntCtl_t;

endpackage

// File: rtl/ow_pullup_cnt.sv
module ow_pullup_cnt
  import ow_pullup_pkg::*;
#(
  parameter int WIN_STD = 8,
  parameter int WIN_OD  = 3,
  parameter int TMO_CYC = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCtl_t ctl,
  input  logic    speedOd,
  output logic    winExp,
  output logic    tmoExp
);

  localparam int MAX_CYC = (TMO_CYC > WIN_STD) ?
                           ((TMO_CYC > WIN_OD) ? TMO_CYC : WIN_OD) :
                           ((WIN_STD > WIN_OD) ? WIN_STD : WIN_OD);
  localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_STD = CNT_W'(WIN_STD - 1);
  localparam logic [CNT_W-1:0] LAST_OD  = CNT_W'(WIN_OD - 1);
  localparam logic [CNT_W-1:0] LAST_TMO = CNT_W'(TMO_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_MAX = CNT_W'(MAX_CYC - 1);

  logic [CNT_W-1:0] cycCnt;

  always_ff @(posedge clk) begin
    if (!rstN)        cycCnt <= '0;
    else if (ctl.clr) cycCnt <= '0;
    else if (ctl.inc) cycCnt <= cycCnt + 1'b1;
  end

  always_comb begin
    winExp = (cycCnt == (speedOd ? LAST_OD : LAST_STD));
    tmoExp = (cycCnt == LAST_TMO);
  end

  // R7: the counter is always stopped at the last cycle of a window or timeout
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cycCnt <= LAST_MAX);

  // R4: a clear always lands at zero
  a_r4_clr_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (cycCnt == '0));

endmodule

// File: rtl/ow_pullup_ctrl.sv
module ow_pullup_ctrl
  import ow_pullup_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    apuEn,
  input  logic    spuEn,
  input  logic    releaseEvt,
  input  logic    skipEdge,
  input  logic    aboveThresh,
  input  logic    slotEnd,
  input  logic    cmdStrobe,
  input  logic    winExp,
  input  logic    tmoExp,
  output cntCtl_t ctl,
  output logic    pullupOn,
  output logic    pwrCtlN,
  output logic    spuDone
);

  seqState_t state, nxtState;
  logic      spuDoneQ;

  always_comb begin
    nxtState = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: if (releaseEvt && apuEn && !skipEdge) begin
        nxtState = ST_WAIT;
        ctl.clr  = 1'b1;
      end
      ST_WAIT: begin
        if (aboveThresh) begin
          nxtState = ST_APU;
          ctl.clr  = 1'b1;
        end else if (tmoExp) begin
          nxtState = ST_IDLE;
        end else begin
          ctl.inc = 1'b1;
        end
      end
      ST_APU: begin
        if (winExp) nxtState = ST_IDLE;
        else        ctl.inc  = 1'b1;
      end
      ST_SPU: if (cmdStrobe) nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
    // an armed strong pullup wins over any assist activity
    if (state != ST_SPU && slotEnd && spuEn) nxtState = ST_SPU;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      spuDoneQ <= 1'b0;
    end else begin
      state    <= nxtState;
      spuDoneQ <= (state == ST_SPU) && cmdStrobe;
    end
  end

  always_comb begin
    pullupOn = (state == ST_APU) || (state == ST_SPU);
    pwrCtlN  = (state != ST_SPU);
    spuDone  = spuDoneQ;
  end

  // R9: the done pulse lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    spuDone |=> !spuDone);

  // R9: the done pulse follows the end of strong pullup
  a_r9_done_after_spu: assert property (@(posedge clk) disable iff (!rstN)
    spuDone |-> (pwrCtlN && !pullupOn && $past(!pwrCtlN)));

  // R8: strong pullup holds until a command strobe
  a_r8_spu_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrCtlN && !cmdStrobe) |=> !pwrCtlN);

  // R3: an assist pulse starts only on a sampled threshold crossing
  a_r3_needs_thresh: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pullupOn) && pwrCtlN) |-> $past(aboveThresh));

  // R8: the external pin is never asserted without the transistor
  a_r8_pin_with_fet: assert property (@(posedge clk) disable iff (!rstN)
    !pwrCtlN |-> pullupOn);

endmodule

// File: rtl/ow_pullup_seq.sv
module ow_pullup_seq
  import ow_pullup_pkg::*;
#(
  parameter int WIN_STD = 8,
  parameter int WIN_OD  = 3,
  parameter int TMO_CYC = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic apuEn,
  input  logic spuEn,
  input  logic speedOd,
  input  logic releaseEvt,
  input  logic skipEdge,
  input  logic aboveThresh,
  input  logic slotEnd,
  input  logic cmdStrobe,
  output logic pullupOn,
  output logic pwrCtlN,
  output logic spuDone
);

  cntCtl_t cntCtl;
  logic    winExp;
  logic    tmoExp;

  ow_pullup_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .apuEn      (apuEn),
    .spuEn      (spuEn),
    .releaseEvt (releaseEvt),
    .skipEdge   (skipEdge),
    .aboveThresh(aboveThresh),
    .slotEnd    (slotEnd),
    .cmdStrobe  (cmdStrobe),
    .winExp     (winExp),
    .tmoExp     (tmoExp),
    .ctl        (cntCtl),
    .pullupOn   (pullupOn),
    .pwrCtlN    (pwrCtlN),
    .spuDone    (spuDone)
  );

  ow_pullup_cnt #(
    .WIN_STD(WIN_STD),
    .WIN_OD (WIN_OD),
    .TMO_CYC(TMO_CYC)
  ) cnt_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (cntCtl),
    .speedOd(speedOd),
    .winExp (winExp),
    .tmoExp (tmoExp)
  );

endmodule

// File: tb/ow_pullup_seq_tb_top.sv
module ow_pullup_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_STD = 8;
  localparam int WIN_OD  = 3;
  localparam int TMO_CYC = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic apuEn = 1'b0, spuEn = 1'b0, speedOd = 1'b0;
  logic releaseEvt = 1'b0, skipEdge = 1'b0, aboveThresh = 1'b0;
  logic slotEnd = 1'b0, cmdStrobe = 1'b0;
  logic pullupOn, pwrCtlN, spuDone;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_pullup_seq #(.WIN_STD(WIN_STD), .WIN_OD(WIN_OD), .TMO_CYC(TMO_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .apuEn(apuEn), .spuEn(spuEn), .speedOd(speedOd),
    .releaseEvt(releaseEvt), .skipEdge(skipEdge), .aboveThresh(aboveThresh),
    .slotEnd(slotEnd), .cmdStrobe(cmdStrobe),
    .pullupOn(pullupOn), .pwrCtlN(pwrCtlN), .spuDone(spuDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doRelease(input logic skip);
    @(negedge clk); releaseEvt = 1'b1; skipEdge = skip;
    @(negedge clk); releaseEvt = 1'b0; skipEdge = 1'b0;
  endtask

  // number of consecutive sampled cycles with pullupOn high
  task automatic measureHigh(output int n);
    n = 0;
    while (pullupOn && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    chk("R1 pullupOn", pullupOn, 0);
    chk("R1 pwrCtlN", pwrCtlN, 1);
    chk("R1 spuDone", spuDone, 0);
  endtask

  task automatic testApuOff();
    int hits = 0;
    apuEn = 1'b0;
    doRelease(1'b0);
    aboveThresh = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pullupOn) hits++;
    end
    aboveThresh = 1'b0;
    chk("R2 no assist when disabled", hits, 0);
  endtask

  task automatic testApuWindow(input logic od, input int expWin, input string req);
    int n;
    int pinLow = 0;
    apuEn = 1'b1; speedOd = od;
    doRelease(1'b0);
    repeat (3) @(negedge clk);
    chk("R3 waits for threshold", pullupOn, 0);
    aboveThresh = 1'b1;
    @(negedge clk); aboveThresh = 1'b0;
    chk("R3 on after threshold", pullupOn, 1);
    n = 0;
    while (pullupOn && n < 200) begin
      if (!pwrCtlN) pinLow++;
      n++;
      @(negedge clk);
    end
    chk(req, n, expWin);
    chk("R4 pin idle during assist", pinLow, 0);
    speedOd = 1'b0;
  endtask

  task automatic testSkip();
    int hits = 0;
    apuEn = 1'b1;
    doRelease(1'b1);
    @(negedge clk);
    aboveThresh = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (pullupOn) hits++;
    end
    aboveThresh = 1'b0;
    chk("R6 skipped edge", hits, 0);
  endtask

  task automatic testTimeout();
    int hits = 0;
    apuEn = 1'b1;
    doRelease(1'b0);
    repeat (TMO_CYC + 2) @(negedge clk);
    aboveThresh = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (pullupOn) hits++;
    end
    aboveThresh = 1'b0;
    chk("R7 timeout to idle", hits, 0);
  endtask

  task automatic endSpu();
    @(negedge clk); cmdStrobe = 1'b1;
    @(negedge clk); cmdStrobe = 1'b0;
    chk("R9 pullup released", pullupOn, 0);
    chk("R9 pin released", pwrCtlN, 1);
    chk("R9 done pulse", spuDone, 1);
    spuEn = 1'b0;
    @(negedge clk);
    chk("R9 done one cycle", spuDone, 0);
  endtask

  task automatic testSpu();
    int drops = 0;
    apuEn = 1'b0; spuEn = 1'b1;
    @(negedge clk); slotEnd = 1'b1;
    @(negedge clk); slotEnd = 1'b0;
    chk("R8 pullup on", pullupOn, 1);
    chk("R8 pin asserted", pwrCtlN, 0);
    repeat (2 * WIN_STD + 3) begin
      @(negedge clk);
      if (!pullupOn || pwrCtlN) drops++;
    end
    chk("R8 held past window", drops, 0);
    endSpu();
  endtask

  task automatic testPreempt();
    int drops = 0;
    apuEn = 1'b1;
    doRelease(1'b0);
    aboveThresh = 1'b1;
    @(negedge clk); aboveThresh = 1'b0;
    @(negedge clk);
    spuEn = 1'b1; slotEnd = 1'b1;
    @(negedge clk); slotEnd = 1'b0;
    chk("R10 pin asserted", pwrCtlN, 0);
    repeat (WIN_STD + 4) begin
      @(negedge clk);
      if (!pullupOn || pwrCtlN) drops++;
    end
    chk("R10 beyond window", drops, 0);
    endSpu();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testApuOff();
    testApuWindow(1'b0, WIN_STD, "R4 std window");
    testApuWindow(1'b1, WIN_OD, "R5 od window");
    testSkip();
    testTimeout();
    testSpu();
    testPreempt();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule